// File: doc/BRIEF.md
# DSP Data Address Generator

This block forms the 16-bit data-memory address for each operand access of a small DSP core. A request is either direct or indirect. A direct request joins a 9-bit page register with a 7-bit offset taken from the instruction. An indirect request reads one of eight 16-bit pointer registers. A 3-bit selector picks that register.

On an indirect access, the selected pointer register is post-modified in the same cycle. The rule is one of several: hold, step by one up or down, step by the index register (pointer register 0) up or down, or step by the index register with reverse carry. The reverse-carry step walks a buffer in the bit-reversed order that an FFT needs. After the update, the selector may take a new value that applies from the next access. A separate write port lets the core load any pointer register, the page register or the selector directly.

The address and its valid strobe come from registers. They appear one clock edge after the request.

Top module: `dag_top`

## Requirements
- R1: A direct request (req_valid=1, req_indirect=0) drives addr_out to {page[8:0], req_offset[6:0]} on the cycle after the request, using the page value held when the request was made.
- R2: addr_valid is 1 on the cycle after a cycle with req_valid=1 and 0 on the cycle after a cycle with req_valid=0. addr_out holds its value while no request arrives.
- R3: An indirect request (req_indirect=1) drives addr_out, on the next cycle, to the selected pointer register's value from before its modification in that cycle.
- R4: Modify codes 0, 1 and 2 leave the selected register unchanged, add 1 and subtract 1. All arithmetic wraps modulo 2^16 and no flag is raised.
- R5: Modify codes 3 and 4 add and subtract the index register (pointer register 0), modulo 2^16.
- R6: Modify codes 5 and 6 add and subtract the index register with reverse carry, meaning the carry or borrow runs from bit 15 toward bit 0. Code 7 leaves the register unchanged.
- R7: When the selected register is the index register itself, the index operand is its value from before the update.
- R8: On an indirect request with req_ptr_load=1, the selector takes req_ptr_val after the modification. The access after that uses the new register.
- R9: A write with wr_en=1 targets a register by wr_sel: values 0 to 7 select a pointer register (all 16 data bits), 8 selects the page register (wr_data[8:0]) and 9 selects the selector (wr_data[2:0]). Values 10 to 15 change nothing. A write to the same register as a same-cycle modification or selector load wins over it.
- R10: A direct request leaves every pointer register and the selector unchanged, whatever req_mod and req_ptr_load are.
- R11: After synchronous active-low reset, addr_out=0 and addr_valid=0, and all pointer registers, the page register and the selector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | An access request is present this cycle |
| req_indirect | input | 1 | 1 = indirect through the selected pointer register, 0 = direct |
| req_offset | input | 7 | In-page offset for a direct request |
| req_mod | input | 3 | Post-modify code for an indirect request |
| req_ptr_load | input | 1 | Load the selector after this indirect access |
| req_ptr_val | input | 3 | New selector value |
| wr_en | input | 1 | External register write enable |
| wr_sel | input | 4 | Write target: 0-7 pointer register, 8 page, 9 selector |
| wr_data | input | 16 | External write data |
| addr_out | output | 16 | Registered data-memory address |
| addr_valid | output | 1 | Registered strobe: addr_out belongs to the previous cycle's request |

## Verification
Every result of this block is due exactly one edge after its stimulus. addr_out and addr_valid reflect the request made before the edge. Register changes from a post-modify, a selector load or an external write show up in the address of the next indirect or direct request, which lands one further edge later.

The bench drives inputs on the falling edge. It updates a reference model at the rising edge and compares addr_out and addr_valid on the following falling edge. It never samples at the edge where the value changes. Hidden register state is checked only through the addresses of later requests.

// File: rtl/dag_pkg.sv
// Shared definitions for the data address generator.
// Assumes the modify code is carried as 3 bits on the request port.
package dag_pkg;
    typedef enum logic [2:0] {
        MOD_HOLD  = 3'd0,
        MOD_INC   = 3'd1,
        MOD_DEC   = 3'd2,
        MOD_ADDX  = 3'd3,
        MOD_SUBX  = 3'd4,
        MOD_RADDX = 3'd5,
        MOD_RSUBX = 3'd6,
        MOD_SPARE = 3'd7
    } mod_e;
endpackage

// File: rtl/dag_revadd.sv
// Reverse-carry adder/subtractor: mirrors both operands, adds or
// subtracts them, and mirrors the result, so carries run MSB to LSB.
// Assumes a purely combinational use inside one cycle.
module dag_revadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] ra, rb, rs;

    // Bit mirroring of operands and result
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign ra[i] = a[W-1-i];
        assign rb[i] = b[W-1-i];
        assign y[i]  = rs[W-1-i];
    end

    // Ordinary add or two's-complement subtract in mirrored domain
    always_comb rs = ra + (sub ? ~rb : rb) + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/dag_postmod.sv
// Computes the post-modified value of the selected pointer register.
// Assumes idx is the index register value from before this cycle's update.
module dag_postmod
    import dag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] idx,
    input  logic [2:0]   mod,
    output logic [W-1:0] nxt
);
    logic [W-1:0] rev_y;
    logic         rev_sub;

    assign rev_sub = (mod_e'(mod) == MOD_RSUBX);

    dag_revadd #(.W(W)) u_rev (
        .a   (cur),
        .b   (idx),
        .sub (rev_sub),
        .y   (rev_y)
    );

    // Select the modification rule
    always_comb begin
        unique case (mod_e'(mod))
            MOD_INC:   nxt = cur + W'(1);
            MOD_DEC:   nxt = cur - W'(1);
            MOD_ADDX:  nxt = cur + idx;
            MOD_SUBX:  nxt = cur - idx;
            MOD_RADDX,
            MOD_RSUBX: nxt = rev_y;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/dag_regfile.sv
// Pointer registers, page register and selector with write priority.
// Assumes upd_en is asserted only for indirect accesses; the external
// write is applied after the access update so it wins a collision.
module dag_regfile #(
    parameter int W    = 16,
    parameter int NPTR = 8,
    parameter int PW   = 9,
    localparam int SW  = $clog2(NPTR),
    localparam int WSW = $clog2(NPTR + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_en,
    input  logic [W-1:0]           upd_val,
    input  logic                   ptr_load,
    input  logic [SW-1:0]          ptr_val,
    input  logic                   wr_en,
    input  logic [WSW-1:0]         wr_sel,
    input  logic [W-1:0]           wr_data,
    output logic [NPTR-1:0][W-1:0] ptr_q,
    output logic [SW-1:0]          sel_q,
    output logic [PW-1:0]          page_q
);
    // Pointer registers: access update then external write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            if (upd_en)
                ptr_q[sel_q] <= upd_val;
            if (wr_en && wr_sel < WSW'(NPTR))
                ptr_q[wr_sel[SW-1:0]] <= wr_data;
        end
    end

    // Selector: access load then external write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            if (upd_en && ptr_load)
                sel_q <= ptr_val;
            if (wr_en && wr_sel == WSW'(NPTR + 1))
                sel_q <= wr_data[SW-1:0];
        end
    end

    // Page register: external write only
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (wr_en && wr_sel == WSW'(NPTR))
            page_q <= wr_data[PW-1:0];
    end

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en) |=> ($stable(ptr_q) && $stable(sel_q) && $stable(page_q)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel < WSW'(NPTR)) |=> ptr_q[$past(wr_sel[SW-1:0])] == $past(wr_data));

    // R8
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && ptr_load && !wr_en) |=> sel_q == $past(ptr_val));
endmodule

// File: rtl/dag_top.sv
// Data address generator top: forms direct or indirect addresses,
// post-modifies the selected pointer register, and registers the output.
// Assumes W == PW + OW so a direct address fills the full width.
module dag_top #(
    parameter int W    = 16,
    parameter int NPTR = 8,
    parameter int PW   = 9,
    parameter int OW   = 7,
    localparam int SW  = $clog2(NPTR),
    localparam int WSW = $clog2(NPTR + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_indirect,
    input  logic [OW-1:0]  req_offset,
    input  logic [2:0]     req_mod,
    input  logic           req_ptr_load,
    input  logic [SW-1:0]  req_ptr_val,
    input  logic           wr_en,
    input  logic [WSW-1:0] wr_sel,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   addr_out,
    output logic           addr_valid
);
    logic [NPTR-1:0][W-1:0] ptr_q;
    logic [SW-1:0]          sel_q;
    logic [PW-1:0]          page_q;
    logic [W-1:0]           cur_val;
    logic [W-1:0]           nxt_val;
    logic                   upd_en;

    initial assert (W == PW + OW) else $error("page plus offset width must equal W");

    assign upd_en  = req_valid && req_indirect;
    assign cur_val = ptr_q[sel_q];

    dag_postmod #(.W(W)) u_mod (
        .cur (cur_val),
        .idx (ptr_q[0]),
        .mod (req_mod),
        .nxt (nxt_val)
    );

    dag_regfile #(.W(W), .NPTR(NPTR), .PW(PW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_val  (nxt_val),
        .ptr_load (req_ptr_load),
        .ptr_val  (req_ptr_val),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ptr_q    (ptr_q),
        .sel_q    (sel_q),
        .page_q   (page_q)
    );

    // Output register: address and strobe one edge after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid)
                addr_out <= req_indirect ? cur_val : {page_q, req_offset};
        end
    end

    // R1
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_indirect) |=> addr_out == {$past(page_q), $past(req_offset)});

    // R2
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(addr_out)));

    // R3
    indirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> addr_out == $past(ptr_q[sel_q]));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && req_mod == 3'd1 && !wr_en) |=> ptr_q[$past(sel_q)] == $past(cur_val) + W'(1));
endmodule

// File: tb/dag_top_test.sv
`timescale 1ns/1ps
module dag_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_indirect = 1'b0;
    logic [6:0]  req_offset = '0;
    logic [2:0]  req_mod = '0;
    logic        req_ptr_load = 1'b0;
    logic [2:0]  req_ptr_val = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] addr_out;
    logic        addr_valid;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_ptr [8];
    logic [8:0]  m_page;
    logic [2:0]  m_sel;
    logic [15:0] m_addr;

    always #2.5 clk = ~clk;

    dag_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indirect(req_indirect),
        .req_offset(req_offset), .req_mod(req_mod), .req_ptr_load(req_ptr_load),
        .req_ptr_val(req_ptr_val), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    // Reverse-carry add/sub: carry runs from bit 15 down to bit 0
    function automatic logic [15:0] rc_op(input logic [15:0] a, input logic [15:0] b, input bit sub);
        logic [15:0] bb = sub ? ~b : b;
        logic c = sub;
        logic [15:0] s;
        for (int i = 15; i >= 0; i--) begin
            s[i] = a[i] ^ bb[i] ^ c;
            c = (a[i] & bb[i]) | (a[i] & c) | (bb[i] & c);
        end
        return s;
    endfunction

    function automatic logic [15:0] next_val(input logic [15:0] v, input logic [15:0] x, input logic [2:0] m);
        case (m)
            3'd1: return v + 16'd1;
            3'd2: return v - 16'd1;
            3'd3: return v + x;
            3'd4: return v - x;
            3'd5: return rc_op(v, x, 1'b0);
            3'd6: return rc_op(v, x, 1'b1);
            default: return v;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(input string tag, input bit v, input bit ind, input logic [6:0] off,
                        input logic [2:0] md, input bit pl, input logic [2:0] pv,
                        input bit we, input logic [3:0] ws, input logic [15:0] wd);
        logic [15:0] old0;
        req_valid = v; req_indirect = ind; req_offset = off; req_mod = md;
        req_ptr_load = pl; req_ptr_val = pv; wr_en = we; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        if (v) begin
            m_addr = ind ? m_ptr[m_sel] : {m_page, off};
            if (ind) begin
                old0 = m_ptr[0];
                m_ptr[m_sel] = next_val(m_ptr[m_sel], old0, md);
                if (pl) m_sel = pv;
            end
        end
        if (we) begin
            if (ws < 4'd8) m_ptr[ws[2:0]] = wd;
            else if (ws == 4'd8) m_page = wd[8:0];
            else if (ws == 4'd9) m_sel = wd[2:0];
        end
        @(negedge clk);
        check({tag, " strobe"}, {15'd0, addr_valid}, {15'd0, v});
        check(tag, addr_out, m_addr);
    endtask

    task automatic wr(input string tag, input logic [3:0] ws, input logic [15:0] wd);
        step(tag, 0, 0, 7'd0, 3'd0, 0, 3'd0, 1, ws, wd);
    endtask

    task automatic ind(input string tag, input logic [2:0] md);
        step(tag, 1, 1, 7'd0, md, 0, 3'd0, 0, 4'd0, 16'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) m_ptr[i] = '0;
        m_page = '0; m_sel = '0; m_addr = '0;
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11 addr", addr_out, 16'd0);
        check("R11 strobe", {15'd0, addr_valid}, 16'd0);
        rst_n = 1'b1;
        ind("R11 ptr0 zero", 3'd0);
        step("R2 idle", 0, 0, 7'd0, 3'd0, 0, 3'd0, 0, 4'd0, 16'd0);
        // R1 and R9: page write then direct
        wr("R9 page", 4'd8, 16'hF1AB);
        step("R1 direct", 1, 0, 7'h55, 3'd0, 0, 3'd0, 0, 4'd0, 16'd0);
        // R4 wrap
        wr("R9 ptr1", 4'd1, 16'hFFFF);
        wr("R9 sel", 4'd9, 16'h0001);
        ind("R4 inc", 3'd1);
        ind("R4 wrap up", 3'd0);
        ind("R4 dec", 3'd2);
        ind("R4 wrap down", 3'd0);
        // R5
        wr("R9 idx", 4'd0, 16'h0010);
        ind("R5 add", 3'd3);
        ind("R5 sub", 3'd4);
        ind("R5 after", 3'd0);
        // R6: bit-reversed walk
        wr("R9 idx", 4'd0, 16'h0008);
        wr("R9 ptr2", 4'd2, 16'h0000);
        wr("R9 sel", 4'd9, 16'h0002);
        for (int i = 0; i < 8; i++) ind("R6 radd", 3'd5);
        for (int i = 0; i < 8; i++) ind("R6 rsub", 3'd6);
        ind("R6 spare", 3'd7);
        ind("R6 spare hold", 3'd0);
        // R7: index modifies itself
        wr("R9 sel", 4'd9, 16'h0000);
        wr("R9 idx", 4'd0, 16'h0005);
        ind("R7 self add", 3'd3);
        ind("R7 result", 3'd0);
        // R8: selector load
        wr("R9 ptr3", 4'd3, 16'hBEEF);
        step("R8 load", 1, 1, 7'd0, 3'd1, 1, 3'd3, 0, 4'd0, 16'd0);
        ind("R8 new sel", 3'd1);
        // R9: collision, write wins
        step("R9 collide", 1, 1, 7'd0, 3'd1, 0, 3'd0, 1, 4'd3, 16'h1234);
        ind("R9 collide result", 3'd0);
        step("R9 sel collide", 1, 1, 7'd0, 3'd0, 1, 3'd5, 1, 4'd9, 16'h0006);
        wr("R9 ignored sel", 4'd12, 16'hAAAA);
        ind("R9 ignored result", 3'd0);
        // R10: direct ignores modify and selector load
        step("R10 direct", 1, 0, 7'h7F, 3'd1, 1, 3'd2, 0, 4'd0, 16'd0);
        ind("R10 unchanged", 3'd0);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit v  = ($urandom % 10) != 0;
            bit id = ($urandom % 4) != 0;
            step(id ? "R3 random" : "R1 random", v, id, 7'($urandom), 3'($urandom),
                 ($urandom % 3) == 0, 3'($urandom), ($urandom % 5) == 0,
                 4'($urandom), 16'($urandom));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule